// File: doc/BRIEF.md
# VGA Frame Buffer Scan-Out Controller

This block drives a 640 by 480, 60 Hz VGA raster from a quarter-resolution image of 320 by 240 one-byte pixels. Each byte packs a 3-bit red, a 3-bit green and a 2-bit blue field. The block splits these fields out for an 8-bit resistor DAC, and each stored pixel is shown as a 2 by 2 block on screen. Two free-running counters track the column and the line. From them the block derives active-low horizontal and vertical sync, the blanking intervals and the image address.

The image store sits outside the block. It is a simple dual-port RAM on the pixel clock with one registered read port, so data comes back one clock after the address is presented. Other logic writes the image through the RAM's own write port. The block issues each read address two clocks before the matching pixel leaves its output registers. It delays the sync and blanking information by the same amount, so every output of a given screen position appears on the same clock. A one-clock frame-start pulse marks the first visible pixel, so writers can synchronise their updates with the scan.

Top module: `vga_scanout`

## Requirements
- R1: A synchronous active-low reset drives hsync_n and vsync_n to 1 and red, green, blue, sof and rd_addr to 0. After reset is released, the raster restarts at column 0, line 0, and the first visible pixel leaves the outputs two clocks later.
- R2: A line lasts 800 clocks: 640 visible, 16 front porch, 96 sync and 48 back porch. hsync_n is low exactly for output columns 656 to 751.
- R3: A frame lasts 525 lines: 480 visible, 10 front porch, 2 sync and 33 back porch. vsync_n is low exactly during lines 490 and 491.
- R4: When the counters sit at column h, line v (n clocks after reset release, in raster order), rd_addr equals (v/2)*320 + h/2 while h < 640 and v < 480, and 0 otherwise. It never exceeds 76799.
- R5: The byte returned for an address appears on the outputs two clocks after that address was issued, with red = byte bits 7:5, green = byte bits 4:2 and blue = byte bits 1:0.
- R6: Columns 2k and 2k+1 read the same address, line 2j+1 repeats the addresses of line 2j, and line 2j+2 starts 320 addresses later.
- R7: Outside the visible area, red, green and blue are 0 whatever value the RAM returns.
- R8: sof is high for exactly one clock per frame, on the clock that shows column 0 of line 0, and both syncs are high at that time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock, shared with the image RAM |
| rst_n | input | 1 | Synchronous reset, active low |
| rd_addr | output | 17 | Read address to the image RAM |
| rd_data | input | 8 | Registered RAM read data, one clock after rd_addr |
| red | output | 3 | Red DAC field |
| green | output | 3 | Green DAC field |
| blue | output | 2 | Blue DAC field |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| sof | output | 1 | One-clock pulse with the first visible pixel of a frame |

## Verification
A column counter that is off by any amount moves the hsync_n edges and the rd_addr sequence within the first line, that is, inside 800 clocks of reset. A line counter error moves the start of vsync_n or sof by one frame, and the reduced-raster instance exposes it within a few hundred clocks. If the control delay does not match the read latency, colours are shifted one column against the syncs. That shows on the first visible clocks as a wrong pixel value or as colour leaking into column 640. A swapped colour field shows on the first pixel whose byte is not symmetric in its fields.

// File: rtl/vga_scan_pkg.sv
// Package: shared control word for the scan-out pipeline.
// Assumes: all sync flags active low; idle value matches reset state.
package vga_scan_pkg;

    typedef struct packed {
        logic hsync_n;   // horizontal sync, active low
        logic vsync_n;   // vertical sync, active low
        logic active;    // position lies in the visible area
        logic first;     // position is column 0 of line 0
    } scan_ctl_t;

    localparam scan_ctl_t CTL_IDLE = '{hsync_n: 1'b1, vsync_n: 1'b1,
                                       active: 1'b0, first: 1'b0};

endpackage

// File: rtl/vga_raster_timer.sv
// Raster timer: column and line counters plus decoded sync and blanking.
// Assumes: one count per pixel clock; porch and sync lengths are nonzero.
module vga_raster_timer
    import vga_scan_pkg::*;
#(
    parameter int H_ACTIVE = 640,
    parameter int H_FP     = 16,
    parameter int H_SYNC   = 96,
    parameter int H_BP     = 48,
    parameter int V_ACTIVE = 480,
    parameter int V_FP     = 10,
    parameter int V_SYNC   = 2,
    parameter int V_BP     = 33,
    parameter int HW       = $clog2(H_ACTIVE + H_FP + H_SYNC + H_BP),
    parameter int VW       = $clog2(V_ACTIVE + V_FP + V_SYNC + V_BP)
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [HW-1:0] h_cnt,
    output logic [VW-1:0] v_cnt,
    output scan_ctl_t     ctl
);

    localparam int H_TOTAL = H_ACTIVE + H_FP + H_SYNC + H_BP;
    localparam int V_TOTAL = V_ACTIVE + V_FP + V_SYNC + V_BP;
    localparam logic [HW-1:0] H_LAST    = HW'(H_TOTAL - 1);
    localparam logic [VW-1:0] V_LAST    = VW'(V_TOTAL - 1);
    localparam logic [HW-1:0] H_VIS     = HW'(H_ACTIVE);
    localparam logic [VW-1:0] V_VIS     = VW'(V_ACTIVE);
    localparam logic [HW-1:0] H_SYN_BEG = HW'(H_ACTIVE + H_FP);
    localparam logic [HW-1:0] H_SYN_END = HW'(H_ACTIVE + H_FP + H_SYNC);
    localparam logic [VW-1:0] V_SYN_BEG = VW'(V_ACTIVE + V_FP);
    localparam logic [VW-1:0] V_SYN_END = VW'(V_ACTIVE + V_FP + V_SYNC);

    // Advance the column each clock; wrap into the next line and frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            h_cnt <= '0;
            v_cnt <= '0;
        end else if (h_cnt == H_LAST) begin
            h_cnt <= '0;
            v_cnt <= (v_cnt == V_LAST) ? '0 : v_cnt + 1'b1;
        end else begin
            h_cnt <= h_cnt + 1'b1;
        end
    end

    // Decode sync, visibility and frame start from the current position.
    always_comb begin
        ctl.hsync_n = !((h_cnt >= H_SYN_BEG) && (h_cnt < H_SYN_END));
        ctl.vsync_n = !((v_cnt >= V_SYN_BEG) && (v_cnt < V_SYN_END));
        ctl.active  = (h_cnt < H_VIS) && (v_cnt < V_VIS);
        ctl.first   = (h_cnt == '0) && (v_cnt == '0);
    end

endmodule

// File: rtl/vga_fetch_addr.sv
// Fetch address generator: maps a raster position to a half-resolution
// image word, row-major. Assumes the visible width and height are even.
module vga_fetch_addr #(
    parameter int H_ACTIVE = 640,
    parameter int HW       = 10,
    parameter int VW       = 10,
    parameter int ADDR_W   = 17
) (
    input  logic [HW-1:0]     h_cnt,
    input  logic [VW-1:0]     v_cnt,
    input  logic              active,
    output logic [ADDR_W-1:0] rd_addr
);

    localparam int COLS = H_ACTIVE / 2;

    logic [ADDR_W-1:0] col_w;
    logic [ADDR_W-1:0] row_w;

    // Halve both coordinates and form row*COLS + col; park at 0 in blanking.
    always_comb begin
        col_w   = ADDR_W'(h_cnt >> 1);
        row_w   = ADDR_W'(v_cnt >> 1);
        rd_addr = active ? (row_w * ADDR_W'(COLS) + col_w) : '0;
    end

endmodule

// File: rtl/vga_pixel_pipe.sv
// Pixel pipe: delays the control word by the RAM read latency, then
// registers syncs, frame start and the unpacked, blank-masked colour.
// Assumes: rd_data is valid RD_LAT clocks after its address.
module vga_pixel_pipe
    import vga_scan_pkg::*;
#(
    parameter int RD_LAT = 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  scan_ctl_t  ctl_in,
    input  logic [7:0] pix_byte,
    output logic [2:0] red,
    output logic [2:0] green,
    output logic [1:0] blue,
    output logic       hsync_n,
    output logic       vsync_n,
    output logic       sof
);

    scan_ctl_t ctl_q [RD_LAT];

    // Shift the control word so it lines up with the returning RAM byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < RD_LAT; i++) ctl_q[i] <= CTL_IDLE;
        end else begin
            ctl_q[0] <= ctl_in;
            for (int i = 1; i < RD_LAT; i++) ctl_q[i] <= ctl_q[i-1];
        end
    end

    // Output register: split the colour fields, force black outside view.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            red     <= '0;
            green   <= '0;
            blue    <= '0;
            hsync_n <= 1'b1;
            vsync_n <= 1'b1;
            sof     <= 1'b0;
        end else begin
            red     <= ctl_q[RD_LAT-1].active ? pix_byte[7:5] : 3'd0;
            green   <= ctl_q[RD_LAT-1].active ? pix_byte[4:2] : 3'd0;
            blue    <= ctl_q[RD_LAT-1].active ? pix_byte[1:0] : 2'd0;
            hsync_n <= ctl_q[RD_LAT-1].hsync_n;
            vsync_n <= ctl_q[RD_LAT-1].vsync_n;
            sof     <= ctl_q[RD_LAT-1].first;
        end
    end

endmodule

// File: rtl/vga_scanout.sv
// Top: VGA scan-out of a half-resolution 3-3-2 byte image held in an
// external registered-read RAM. Assumes RAM and block share clk.
module vga_scanout
    import vga_scan_pkg::*;
#(
    parameter int H_ACTIVE = 640,
    parameter int H_FP     = 16,
    parameter int H_SYNC   = 96,
    parameter int H_BP     = 48,
    parameter int V_ACTIVE = 480,
    parameter int V_FP     = 10,
    parameter int V_SYNC   = 2,
    parameter int V_BP     = 33,
    parameter int RD_LAT   = 1,
    parameter int ADDR_W   = $clog2((H_ACTIVE / 2) * (V_ACTIVE / 2))
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [7:0]        rd_data,
    output logic [2:0]        red,
    output logic [2:0]        green,
    output logic [1:0]        blue,
    output logic              hsync_n,
    output logic              vsync_n,
    output logic              sof
);

    localparam int HW = $clog2(H_ACTIVE + H_FP + H_SYNC + H_BP);
    localparam int VW = $clog2(V_ACTIVE + V_FP + V_SYNC + V_BP);

    logic [HW-1:0] h_cnt;
    logic [VW-1:0] v_cnt;
    scan_ctl_t     ctl;

    vga_raster_timer #(
        .H_ACTIVE(H_ACTIVE), .H_FP(H_FP), .H_SYNC(H_SYNC), .H_BP(H_BP),
        .V_ACTIVE(V_ACTIVE), .V_FP(V_FP), .V_SYNC(V_SYNC), .V_BP(V_BP),
        .HW(HW), .VW(VW)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .h_cnt (h_cnt),
        .v_cnt (v_cnt),
        .ctl   (ctl)
    );

    vga_fetch_addr #(
        .H_ACTIVE(H_ACTIVE), .HW(HW), .VW(VW), .ADDR_W(ADDR_W)
    ) u_fetch (
        .h_cnt   (h_cnt),
        .v_cnt   (v_cnt),
        .active  (ctl.active),
        .rd_addr (rd_addr)
    );

    vga_pixel_pipe #(
        .RD_LAT(RD_LAT)
    ) u_pipe (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctl_in   (ctl),
        .pix_byte (rd_data),
        .red      (red),
        .green    (green),
        .blue     (blue),
        .hsync_n  (hsync_n),
        .vsync_n  (vsync_n),
        .sof      (sof)
    );

endmodule

// File: rtl/vga_scanout_chk.sv
// Checker: port-level timing properties of vga_scanout, bound below.
// Assumes: reset is synchronous and active low.
module vga_scanout_chk #(
    parameter int H_SYNC    = 96,
    parameter int H_TOTAL   = 800,
    parameter int IMG_WORDS = 76800,
    parameter int ADDR_W    = 17
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [2:0]        red,
    input logic [2:0]        green,
    input logic [1:0]        blue,
    input logic              hsync_n,
    input logic              vsync_n,
    input logic              sof
);

    logic [15:0] low_len;
    logic [15:0] since_fall;
    logic        fall_seen;

    // Length of the current hsync_n low run.
    always_ff @(posedge clk) begin
        if (!rst_n) low_len <= '0;
        else        low_len <= hsync_n ? 16'd0 : low_len + 16'd1;
    end

    // Clocks since the last hsync_n falling edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_fall <= '0;
            fall_seen  <= 1'b0;
        end else if (!hsync_n && $past(hsync_n)) begin
            since_fall <= 16'd1;
            fall_seen  <= 1'b1;
        end else if (since_fall != 16'hFFFF) begin
            since_fall <= since_fall + 16'd1;
        end
    end

    AST_HSYNC_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hsync_n) |-> low_len == 16'(H_SYNC)); // R2
    AST_LINE_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(hsync_n) && fall_seen) |-> since_fall == 16'(H_TOTAL)); // R2
    AST_ADDR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        int'(rd_addr) < IMG_WORDS); // R4
    AST_BLANK_DARK: assert property (@(posedge clk) disable iff (!rst_n)
        (|{red, green, blue}) |-> (hsync_n && vsync_n)); // R7
    AST_SOF_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        sof |=> !sof); // R8
    AST_SOF_IN_VIEW: assert property (@(posedge clk) disable iff (!rst_n)
        sof |-> (hsync_n && vsync_n)); // R8

endmodule

bind vga_scanout vga_scanout_chk #(
    .H_SYNC    (H_SYNC),
    .H_TOTAL   (H_ACTIVE + H_FP + H_SYNC + H_BP),
    .IMG_WORDS ((H_ACTIVE / 2) * (V_ACTIVE / 2)),
    .ADDR_W    (ADDR_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_addr (rd_addr),
    .red     (red),
    .green   (green),
    .blue    (blue),
    .hsync_n (hsync_n),
    .vsync_n (vsync_n),
    .sof     (sof)
);

// File: tb/test_vga_scanout.sv
// Directed bench: a full-size instance for line timing and addressing,
// and a reduced-raster instance for frame-level behaviour.
module test_vga_scanout;

    localparam int HALF_NS = 4;

    typedef struct packed {
        int ha; int hf; int hs; int hb; int va; int vf; int vs; int vb;
    } tim_t;

    localparam tim_t BIG   = '{640, 16, 96, 48, 480, 10, 2, 33};
    localparam tim_t SMALL = '{8, 2, 3, 3, 6, 1, 2, 1};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    int   mode = 0;
    int   total = 0;
    int   bad = 0;
    bit   done = 1'b0;

    logic [16:0] b_addr;  logic [7:0] b_q;
    logic [2:0]  b_r, b_g; logic [1:0] b_b; logic b_hs, b_vs, b_sof;
    logic [3:0]  s_addr;  logic [7:0] s_q;
    logic [2:0]  s_r, s_g; logic [1:0] s_b; logic s_hs, s_vs, s_sof;

    always #HALF_NS clk = ~clk;

    vga_scanout i_vga_scanout (
        .clk(clk), .rst_n(rst_n), .rd_addr(b_addr), .rd_data(b_q),
        .red(b_r), .green(b_g), .blue(b_b),
        .hsync_n(b_hs), .vsync_n(b_vs), .sof(b_sof)
    );

    vga_scanout #(
        .H_ACTIVE(8), .H_FP(2), .H_SYNC(3), .H_BP(3),
        .V_ACTIVE(6), .V_FP(1), .V_SYNC(2), .V_BP(1)
    ) i_small_vga_scanout (
        .clk(clk), .rst_n(rst_n), .rd_addr(s_addr), .rd_data(s_q),
        .red(s_r), .green(s_g), .blue(s_b),
        .hsync_n(s_hs), .vsync_n(s_vs), .sof(s_sof)
    );

    function automatic int pat(int m, int a);
        if (m == 0)      return ((a * 37) ^ (a >> 7)) & 255;
        else if (m == 1) return 255;
        else             return (a * 29 + 3) & 255;
    endfunction

    // RAM models: registered read, one clock of latency.
    always_ff @(posedge clk) begin
        b_q <= 8'(pat(mode, int'(b_addr)));
        s_q <= 8'(pat(mode, int'(s_addr)));
    end

    function automatic int exp_addr(tim_t t, int n);
        int ht = t.ha + t.hf + t.hs + t.hb;
        int vt = t.va + t.vf + t.vs + t.vb;
        int p  = n % (ht * vt);
        int h  = p % ht;
        int v  = p / ht;
        if (h < t.ha && v < t.va) return (v / 2) * (t.ha / 2) + h / 2;
        return 0;
    endfunction

    task automatic calc(input tim_t t, input int n, input int m,
                        output int hs, output int vs, output int sf, output int px);
        int ht = t.ha + t.hf + t.hs + t.hb;
        int vt = t.va + t.vf + t.vs + t.vb;
        int p, h, v;
        if (n < 2) begin
            hs = 1; vs = 1; sf = 0; px = 0;
            return;
        end
        p  = (n - 2) % (ht * vt);
        h  = p % ht;
        v  = p / ht;
        hs = (h >= t.ha + t.hf && h < t.ha + t.hf + t.hs) ? 0 : 1;
        vs = (v >= t.va + t.vf && v < t.va + t.vf + t.vs) ? 0 : 1;
        sf = (h == 0 && v == 0) ? 1 : 0;
        px = (h < t.ha && v < t.va) ? pat(m, (v / 2) * (t.ha / 2) + h / 2) : 0;
    endtask

    task automatic chk(string req, string what, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic check_inst(bit sm, int n, string preq);
        int hs, vs, sf, px;
        tim_t t = sm ? SMALL : BIG;
        calc(t, n, mode, hs, vs, sf, px);
        if (sm) begin
            chk("R2", "hsync_n", int'(s_hs), hs);
            chk("R3", "vsync_n", int'(s_vs), vs);
            chk(preq, "pixel", int'({s_r, s_g, s_b}), px);
            chk("R8", "sof", int'(s_sof), sf);
            chk("R4", "rd_addr", int'(s_addr), exp_addr(t, n));
        end else begin
            chk("R2", "hsync_n", int'(b_hs), hs);
            chk("R3", "vsync_n", int'(b_vs), vs);
            chk(preq, "pixel", int'({b_r, b_g, b_b}), px);
            chk("R8", "sof", int'(b_sof), sf);
            chk("R4", "rd_addr", int'(b_addr), exp_addr(t, n));
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic run_check(bit sm, int cycles, string preq);
        for (int n = 0; n <= cycles; n++) begin
            if (n > 0) begin
                @(posedge clk);
                @(negedge clk);
            end
            check_inst(sm, n, preq);
        end
    endtask

    // R1: values held in reset, then a clean restart of both rasters.
    task automatic t_reset();
        mode = 0;
        rst_n = 1'b0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk("R1", "hsync_n", int'(b_hs), 1);
        chk("R1", "vsync_n", int'(b_vs), 1);
        chk("R1", "colour", int'({b_r, b_g, b_b}), 0);
        chk("R1", "sof", int'(b_sof), 0);
        chk("R1", "rd_addr", int'(b_addr), 0);
        chk("R1", "small sync", int'({s_hs, s_vs}), 3);
        rst_n = 1'b1;
        run_check(0, 10, "R1");
    endtask

    // R2 R4 R5: several full-size lines with a position-dependent pattern.
    task automatic t_big_lines();
        mode = 0;
        do_reset();
        run_check(0, 2500, "R5");
    endtask

    // R6: address sharing between column pairs and line pairs.
    task automatic t_doubling();
        int seen [2401];
        mode = 0;
        do_reset();
        for (int n = 0; n <= 2400; n++) begin
            if (n > 0) begin
                @(posedge clk);
                @(negedge clk);
            end
            seen[n] = int'(b_addr);
        end
        for (int h = 0; h < 640; h += 2) begin
            chk("R6", "column pair", seen[h + 1], seen[h]);
            chk("R6", "line pair", seen[h + 800], seen[h]);
            chk("R6", "next pair", seen[h + 1600], seen[h] + 320);
        end
    endtask

    // R7: RAM returns all ones; blanking must still be black.
    task automatic t_blank();
        mode = 1;
        do_reset();
        run_check(0, 1700, "R7");
    endtask

    // R3 R6 R8: reduced raster over three frames, including wrap.
    task automatic t_small_frames();
        mode = 2;
        do_reset();
        run_check(1, 500, "R6");
    endtask

    // R1: reset in the middle of a frame restarts from column 0, line 0.
    task automatic t_midreset();
        mode = 0;
        do_reset();
        repeat (1234) @(posedge clk);
        do_reset();
        run_check(1, 200, "R1");
    endtask

    initial begin
        t_reset();
        t_big_lines();
        t_doubling();
        t_blank();
        t_small_frames();
        t_midreset();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #(2 * HALF_NS * 100000);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog all actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule